// File: doc/BRIEF.md
# Masked-Attribute Control Register Bank

This block holds a small set of 32-bit control and status registers behind a memory-mapped request/response port. Each register has its own entry in a parameter table. The entry gives its byte address, its reset value and five per-bit masks:

- fixed bits, which writes never change;
- clear-by-writing-one bits;
- reserved bits;
- bits that clear when read;
- bits that are not implemented.

A write merges the incoming data into the stored word. Bits outside the access width and bits protected by the masks keep their old value. A read returns the word cut to the access width and clears the clear-on-read bits that fall inside that width.

Each accepted request gets one registered response. The response carries the read data and three error flags: no register at that address, an attempt to change a reserved bit, and a write of a 1 to an unimplemented bit.

The request side uses a valid/ready handshake, and so does the response side.

- A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no response is pending, or the pending response is being taken in that cycle (`rsp_ready` high).
- A response that is not taken holds all its fields unchanged.
- While that response is held, no new request is accepted.
- The requester must hold its request stable until it is accepted.

Top module: `csr_attr_bank`

## Requirements
- R1: On reset every register loads its own table reset value, `rsp_valid` is 0 and all three flags are 0. The default table is:

  | Byte address | Reset value | Fixed | Clear-by-one | Reserved | Clear-on-read | Not implemented |
  |---|---|---|---|---|---|---|
  | 0x00 | 0x000000A5 | 0xFF000000 | — | 0x0000F000 | — | 0x00F00000 |
  | 0x04 | 0x000000FF | 0xFFFF0000 | 0x000000FF | — | — | — |
  | 0x08 | 0x12345678 | — | — | — | 0x0000FFFF | — |
  | 0x10 | 0xDEADBEEF | — | — | — | — | — |

- R2: On a write, bits that are not fixed, not clear-by-one, not reserved and lie inside the access width take the write data; all other bits keep their old value.
- R3: After that merge, every clear-by-one bit where the write data is 1 becomes 0; writing 0 to such a bit leaves it unchanged.
- R4: `req_size` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Writes change only the low 8, 16 or 32 bits respectively.
- R5: A read returns the stored word ANDed with the access-width mask; bits above the width read as 0. A write response carries `rsp_rdata` = 0.
- R6: A read clears the clear-on-read bits that lie inside its access width. Clear-on-read bits above the width are kept.
- R7: A write with any reserved bit of the data differing from the stored value raises `rsp_rsvd_err`; the reserved bits keep their old value.
- R8: A write whose data has a 1 in any not-implemented bit raises `rsp_unimp_err`. The merge of R2 still applies to those bits.
- R9: A request whose byte address matches no table entry (including a misaligned address) raises `rsp_unmapped`. If it is a read, it returns 0. If it is a write, no register changes.
- R10: The response to a request is valid in the cycle after the request is accepted. A response not taken keeps `rsp_valid` and its data stable, and no request is accepted meanwhile.
- R11: The flags are non-zero only while `rsp_valid` is high, and belong to that response. Register side effects happen only at acceptance, so a read that is waiting under back-pressure clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access width code (R4) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data, width-masked |
| rsp_unmapped | output | 1 | No register at the address |
| rsp_rsvd_err | output | 1 | Write tried to change a reserved bit |
| rsp_unimp_err | output | 1 | Write set a not-implemented bit |

## Verification
Each response and its flags are due exactly one clock edge after the edge that accepts the request. Every register update caused by that request also happens at the accepting edge, so the next access sees it. The bench drives a request at a falling edge, lets one rising edge accept it, and samples the response at the next falling edge. It verifies register contents only through later reads. In the back-pressure scenario the bench counts the stalled edges one by one and checks that the pending response stays unchanged. It then checks that the waiting clear-on-read request had no effect until the edge that finally accepts it.

// File: rtl/csr_attr_pkg.sv
package csr_attr_pkg;

  localparam int DW = 32;
  localparam int TBL_AW = 16;
  localparam int NUM_DEF = 4;

  typedef struct packed {
    logic [TBL_AW-1:0] addr;
    logic [DW-1:0]     rst;
    logic [DW-1:0]     fixed;
    logic [DW-1:0]     clr1;
    logic [DW-1:0]     rsvd;
    logic [DW-1:0]     rdclr;
    logic [DW-1:0]     noimp;
  } attr_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  function automatic attr_t make_attr(input logic [TBL_AW-1:0] a,
                                      input logic [DW-1:0] r,
                                      input logic [DW-1:0] f,
                                      input logic [DW-1:0] c,
                                      input logic [DW-1:0] v,
                                      input logic [DW-1:0] q,
                                      input logic [DW-1:0] n);
    attr_t t;
    t.addr  = a;
    t.rst   = r;
    t.fixed = f;
    t.clr1  = c;
    t.rsvd  = v;
    t.rdclr = q;
    t.noimp = n;
    return t;
  endfunction

  function automatic attr_t [NUM_DEF-1:0] default_attrs();
    attr_t [NUM_DEF-1:0] t;
    t[0] = make_attr(16'h0000, 32'h0000_00A5, 32'hFF00_0000, 32'h0,
                     32'h0000_F000, 32'h0, 32'h00F0_0000);
    t[1] = make_attr(16'h0004, 32'h0000_00FF, 32'hFFFF_0000, 32'h0000_00FF,
                     32'h0, 32'h0, 32'h0);
    t[2] = make_attr(16'h0008, 32'h1234_5678, 32'h0, 32'h0,
                     32'h0, 32'h0000_FFFF, 32'h0);
    t[3] = make_attr(16'h0010, 32'hDEAD_BEEF, 32'h0, 32'h0,
                     32'h0, 32'h0, 32'h0);
    return t;
  endfunction

endpackage

// File: rtl/csr_width_mask.sv
module csr_width_mask
  import csr_attr_pkg::*;
(
  input  logic [1:0]    size,
  output logic [DW-1:0] mask
);

  localparam int REG_BYTES = DW / 8;

  always_comb begin
    int nbytes;
    unique case (size_e'(size))
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      default: nbytes = 4;
    endcase
    if (nbytes > REG_BYTES) nbytes = REG_BYTES;
    mask = '0;
    for (int b = 0; b < REG_BYTES; b++) begin
      if (b < nbytes) mask[b*8 +: 8] = 8'hFF;
    end
  end

endmodule

// File: rtl/csr_addr_match.sv
module csr_addr_match
  import csr_attr_pkg::*;
#(
  parameter int NUM_REGS = NUM_DEF,
  parameter int ADDR_W   = 8,
  parameter attr_t [NUM_REGS-1:0] ATTRS = default_attrs()
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit,
  output logic                any_hit
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    assign hit[i] = (addr == ATTRS[i].addr[ADDR_W-1:0]);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/csr_reg_cell.sv
module csr_reg_cell
  import csr_attr_pkg::*;
#(
  parameter attr_t ATTR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  output logic [DW-1:0] rdata,
  output logic          rsvd_viol,
  output logic          noimp_hit
);

  logic [DW-1:0] q;
  logic [DW-1:0] keep_m;
  logic [DW-1:0] merged;
  logic [DW-1:0] after_wr;
  logic [DW-1:0] after_rd;

  assign keep_m    = ATTR.fixed | ATTR.clr1 | ATTR.rsvd | ~wmask;
  assign merged    = (wdata & ~keep_m) | (q & keep_m);
  assign after_wr  = merged & ~(wdata & ATTR.clr1);
  assign after_rd  = q & ~(ATTR.rdclr & wmask);
  assign rdata     = q & wmask;
  assign rsvd_viol = |((q ^ wdata) & ATTR.rsvd);
  assign noimp_hit = |(wdata & ATTR.noimp);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= ATTR.rst;
    else if (wr_en) q <= after_wr;
    else if (rd_en) q <= after_rd;
  end

  AST_FIXED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ATTR.fixed & ~ATTR.clr1) == ($past(q) & ATTR.fixed & ~ATTR.clr1))); // R2
  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ATTR.rsvd & ~ATTR.clr1) == ($past(q) & ATTR.rsvd & ~ATTR.clr1))); // R7
  AST_RDCLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((q & ATTR.rdclr & $past(wmask)) == '0)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(q)); // R11

endmodule

// File: rtl/csr_attr_bank.sv
module csr_attr_bank
  import csr_attr_pkg::*;
#(
  parameter int NUM_REGS = NUM_DEF,
  parameter int ADDR_W   = 8,
  parameter attr_t [NUM_REGS-1:0] ATTRS = default_attrs()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_unmapped,
  output logic              rsp_rsvd_err,
  output logic              rsp_unimp_err
);

  logic                accept;
  logic [DW-1:0]       wmask;
  logic [NUM_REGS-1:0] hit;
  logic                any_hit;
  logic [DW-1:0]       cell_rd [NUM_REGS];
  logic [NUM_REGS-1:0] cell_rsvd;
  logic [NUM_REGS-1:0] cell_noimp;
  logic [DW-1:0]       rd_mux;
  logic                rsvd_any;
  logic                noimp_any;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  csr_width_mask u_mask (
    .size (req_size),
    .mask (wmask)
  );

  csr_addr_match #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .ATTRS    (ATTRS)
  ) u_match (
    .addr    (req_addr),
    .hit     (hit),
    .any_hit (any_hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    csr_reg_cell #(.ATTR(ATTRS[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (accept && req_write && hit[i]),
      .rd_en     (accept && !req_write && hit[i]),
      .wdata     (req_wdata),
      .wmask     (wmask),
      .rdata     (cell_rd[i]),
      .rsvd_viol (cell_rsvd[i]),
      .noimp_hit (cell_noimp[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rd_mux = rd_mux | cell_rd[i];
    end
  end

  assign rsvd_any  = |(hit & cell_rsvd);
  assign noimp_any = |(hit & cell_noimp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_unmapped  <= 1'b0;
      rsp_rsvd_err  <= 1'b0;
      rsp_unimp_err <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_rdata     <= req_write ? '0 : rd_mux;
      rsp_unmapped  <= !any_hit;
      rsp_rsvd_err  <= req_write && rsvd_any;
      rsp_unimp_err <= req_write && noimp_any;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_unmapped  <= 1'b0;
      rsp_rsvd_err  <= 1'b0;
      rsp_unimp_err <= 1'b0;
    end
  end

  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_unmapped))); // R10
  AST_FLAGS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_unmapped || rsp_rsvd_err || rsp_unimp_err)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> (rsp_rdata == '0)); // R9
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R9

endmodule

// File: tb/sim_csr_attr_bank.sv
`timescale 1ns/1ps
module sim_csr_attr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_size = 2'd2;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_unmapped;
  logic        rsp_rsvd_err;
  logic        rsp_unimp_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] g_rd;
  logic        g_unm, g_rsv, g_uni, g_val;

  always #5 clk = ~clk;

  csr_attr_bank u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_size (req_size),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .rsp_unmapped (rsp_unmapped), .rsp_rsvd_err (rsp_rsvd_err),
    .rsp_unimp_err (rsp_unimp_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    g_val = rsp_valid; g_rd = rsp_rdata;
    g_unm = rsp_unmapped; g_rsv = rsp_rsvd_err; g_uni = rsp_unimp_err;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
    access(1'b0, a, 32'h0, sz);
    check({tag, " valid"}, {31'b0, g_val}, 32'd1);
    check({tag, " rdata"}, g_rd, exp);
    check({tag, " flags"}, {29'b0, g_unm, g_rsv, g_uni}, 32'd0);
  endtask

  task automatic wr_check(input string tag, input logic [7:0] a, input logic [31:0] d,
                          input logic [1:0] sz, input logic [2:0] flags);
    access(1'b1, a, d, sz);
    check({tag, " valid"}, {31'b0, g_val}, 32'd1);
    check({tag, " wr rdata"}, g_rd, 32'h0);
    check({tag, " flags"}, {29'b0, g_unm, g_rsv, g_uni}, {29'b0, flags});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 idle flags", {29'b0, rsp_unmapped, rsp_rsvd_err, rsp_unimp_err}, 32'd0);
    check("R1 idle ready", {31'b0, req_ready}, 32'd1);
    rd_check("R1 reg0", 8'h00, 2'd2, 32'h0000_00A5);
    rd_check("R1 reg1", 8'h04, 2'd2, 32'h0000_00FF);
    rd_check("R1 reg2", 8'h08, 2'd2, 32'h1234_5678);
    rd_check("R1 reg3", 8'h10, 2'd2, 32'hDEAD_BEEF);
  endtask

  task automatic t_merge();
    wr_check("R2 merge wr", 8'h00, 32'h110F_0F5A, 2'd2, 3'b000);
    rd_check("R2 merge rd", 8'h00, 2'd2, 32'h000F_0F5A);
  endtask

  task automatic t_clr1();
    wr_check("R3 clr wr", 8'h04, 32'h0000_AB05, 2'd2, 3'b000);
    rd_check("R3 clr rd", 8'h04, 2'd2, 32'h0000_ABFA);
    wr_check("R3 zero wr", 8'h04, 32'h0000_AB00, 2'd2, 3'b000);
    rd_check("R3 zero rd", 8'h04, 2'd2, 32'h0000_ABFA);
  endtask

  task automatic t_size();
    wr_check("R4 byte wr", 8'h10, 32'h0000_0011, 2'd0, 3'b000);
    rd_check("R4 byte rd", 8'h10, 2'd2, 32'hDEAD_BE11);
    wr_check("R4 half wr", 8'h10, 32'h0000_2233, 2'd1, 3'b000);
    rd_check("R4 half rd", 8'h10, 2'd2, 32'hDEAD_2233);
    wr_check("R4 code3 wr", 8'h10, 32'h4455_6677, 2'd3, 3'b000);
    rd_check("R4 code3 rd", 8'h10, 2'd2, 32'h4455_6677);
    wr_check("R4 byte hi-data wr", 8'h10, 32'hFFFF_FF99, 2'd0, 3'b000);
    rd_check("R4 byte hi-data rd", 8'h10, 2'd2, 32'h4455_6699);
  endtask

  task automatic t_rdwidth();
    rd_check("R5 byte", 8'h10, 2'd0, 32'h0000_0099);
    rd_check("R5 half", 8'h10, 2'd1, 32'h0000_6699);
    rd_check("R5 word", 8'h10, 2'd2, 32'h4455_6699);
  endtask

  task automatic t_rdclr();
    rd_check("R6 after reset read", 8'h08, 2'd2, 32'h1234_0000);
    wr_check("R6 load", 8'h08, 32'hCAFE_BABE, 2'd2, 3'b000);
    rd_check("R6 byte", 8'h08, 2'd0, 32'h0000_00BE);
    rd_check("R6 half", 8'h08, 2'd1, 32'h0000_BA00);
    rd_check("R6 word", 8'h08, 2'd2, 32'hCAFE_0000);
    rd_check("R6 upper kept", 8'h08, 2'd2, 32'hCAFE_0000);
  endtask

  task automatic t_rsvd();
    wr_check("R7 rsvd wr", 8'h00, 32'h000F_FF5A, 2'd2, 3'b010);
    rd_check("R7 rsvd rd", 8'h00, 2'd2, 32'h000F_0F5A);
  endtask

  task automatic t_noimp();
    wr_check("R8 noimp wr", 8'h00, 32'h00F0_0000, 2'd2, 3'b001);
    rd_check("R8 noimp rd", 8'h00, 2'd2, 32'h00F0_0000);
  endtask

  task automatic t_unmapped();
    access(1'b0, 8'h0C, 32'h0, 2'd2);
    check("R9 gap rd data", g_rd, 32'h0);
    check("R9 gap rd flag", {31'b0, g_unm}, 32'd1);
    wr_check("R9 gap wr", 8'h0C, 32'hFFFF_FFFF, 2'd2, 3'b100);
    access(1'b0, 8'h12, 32'h0, 2'd2);
    check("R9 misaligned flag", {31'b0, g_unm}, 32'd1);
    check("R9 misaligned data", g_rd, 32'h0);
    rd_check("R9 reg3 untouched", 8'h10, 2'd2, 32'h4455_6699);
    rd_check("R9 reg1 untouched", 8'h04, 2'd2, 32'h0000_ABFA);
  endtask

  task automatic t_stall();
    wr_check("R10 load reg2", 8'h08, 32'h0000_1111, 2'd2, 3'b000);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10; req_size = 2'd2;
    @(negedge clk);
    check("R10 first rsp valid", {31'b0, rsp_valid}, 32'd1);
    check("R10 first rsp data", rsp_rdata, 32'h4455_6699);
    check("R10 ready low", {31'b0, req_ready}, 32'd0);
    req_addr = 8'h08;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 held data", rsp_rdata, 32'h4455_6699);
      check("R10 held valid", {31'b0, rsp_valid}, 32'd1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 stalled rdclr read data", rsp_rdata, 32'h0000_1111);
    check("R10 second rsp valid", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R11 drop valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 flags idle", {29'b0, rsp_unmapped, rsp_rsvd_err, rsp_unimp_err}, 32'd0);
    rd_check("R11 reg2 cleared once", 8'h08, 2'd2, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_clr1();
    t_size();
    t_rdwidth();
    t_rdclr();
    t_rsvd();
    t_noimp();
    t_unmapped();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule